// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block produces the low-speed timekeeping enable for an always-on domain. Two slow sources reach it as single-cycle pulses in the fast clock domain: one from an internal RC oscillator and one from an external crystal. The block chooses one of them. On the internal path it applies a build-time fixed divide and then a programmable divide by (N+1). The result is a one-cycle enable, `slow_tick`, and a gated copy of it, `pin_en`, that drives an output pin.

Software programs the block through a plain write port (address, data, strobe) and reads it back through a combinational read port. The source-select register guards itself: a write changes it only when the upper half of the data word carries the key 16'h16AA. The divider is a small state machine with three states:

- `ST_RELOAD` is the quiet state after reset or after any accepted configuration write. Its transition `RELOAD->EXT` is taken when the external source is selected, and `RELOAD->INT` otherwise.
- `ST_EXT_PASS` passes the external pulses straight through.
- `ST_INT_COUNT` runs the two counters of the internal path. Both `EXT->RELOAD` and `INT->RELOAD` are forced by an accepted write.

Top module: `slowclk_sel`

## Requirements
- R1: After reset the source is internal, the prescaler is 0 and the pin gate is off. Offsets 0x00, 0x08 and 0x60 read 0, and `slow_tick` is low in the first cycle.
- R2: A write to offset 0x00 takes effect only when wr_data[31:16] equals 16'h16AA; any other key leaves the register unchanged. Bit 0 selects the source: 1 is external, 0 is internal.
- R3: A read of offset 0x00 returns the select in bit 0; every other bit, the key field included, reads 0.
- R4: Offset 0x08 holds the prescaler N in bits [4:0], written with no key. Its upper bits are dropped and read 0.
- R5: Offset 0x60 bit 0 is the pin gate, and it reads back in bit 0.
- R6: With the internal source selected, `slow_tick` pulses once every 32*(N+1) `int_tick` pulses (fixed divide FIXED_DIV, default 32), and only in a cycle where `int_tick` is high.
- R7: With the external source selected, `slow_tick` equals `ext_tick` in the same cycle, and `int_tick` has no effect.
- R8: `pin_en` equals `slow_tick` while the gate is 1 and is held at 0 while the gate is 0.
- R9: An accepted control write or any prescaler write makes `slow_tick` low in the next cycle and restarts the divider. The first internal tick then comes 32*(N+1) source pulses after that quiet cycle. A rejected control write does not disturb the divider.
- R10: Writes to any other offset change nothing, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| int_tick | input | 1 | Internal oscillator pulse |
| ext_tick | input | 1 | External oscillator pulse |
| slow_tick | output | 1 | Selected, divided slow enable |
| pin_en | output | 1 | Gated enable to the output pin |
| sel_ext | output | 1 | Current source select |

## Verification
The bench writes a wrong key to the control register in the middle of a count.

- A design that ignored the key would switch source.
- A design that restarted on the rejected write would deliver the next tick one cycle late.

An accepted prescaler write made in the middle of a period must restart the count. A divider that kept counting would tick early, and one that missed the quiet cycle would pulse right after the write. The bench measures the full internal period at two prescaler values, and a design with an off-by-one on either divide stage misses them. It also checks that the internal pulses are ignored in external mode and that the gate blocks the pin in both modes.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam logic [KEY_W-1:0]  CTRL_KEY  = 16'h16AA;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PRESC = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_GATE  = 8'h60;

    typedef enum logic [1:0] {
        ST_RELOAD    = 2'd0,
        ST_EXT_PASS  = 2'd1,
        ST_INT_COUNT = 2'd2
    } div_state_t;
endpackage

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int PRESC_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                sel_ext,
    output logic [PRESC_W-1:0]  presc,
    output logic                gate_en,
    output logic                cfg_restart
);
    logic ctrl_ok;
    logic presc_wr;
    logic gate_wr;

    // The key field must match exactly before the select can change
    assign ctrl_ok  = wr_en && (wr_addr == OFF_CTRL) &&
                      (wr_data[DATA_W-1:DATA_W-KEY_W] == CTRL_KEY);
    assign presc_wr = wr_en && (wr_addr == OFF_PRESC);
    assign gate_wr  = wr_en && (wr_addr == OFF_GATE);
    assign cfg_restart = ctrl_ok || presc_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_ext <= 1'b0;
            presc   <= '0;
            gate_en <= 1'b0;
        end else begin
            if (ctrl_ok)  sel_ext <= wr_data[0];
            if (presc_wr) presc   <= wr_data[PRESC_W-1:0];
            if (gate_wr)  gate_en <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFF_CTRL:  rd_data[0]           = sel_ext;
            OFF_PRESC: rd_data[PRESC_W-1:0] = presc;
            OFF_GATE:  rd_data[0]           = gate_en;
            default:   rd_data              = '0;
        endcase
    end
endmodule

// File: rtl/clksel_divider.sv
`timescale 1ns/1ps
module clksel_divider
    import clksel_pkg::*;
#(
    parameter int PRESC_W   = 5,
    parameter int FIXED_DIV = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               sel_ext,
    input  logic [PRESC_W-1:0] presc,
    input  logic               int_tick,
    input  logic               ext_tick,
    output logic               slow_tick
);
    localparam int PRE_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

    div_state_t state, state_nxt;
    logic [PRE_W-1:0]   pre_cnt;
    logic [PRESC_W-1:0] main_cnt;
    logic               pre_wrap;
    logic               main_wrap;

    generate
        if (FIXED_DIV > 1) begin : g_fixed
            assign pre_wrap = (pre_cnt == PRE_W'(FIXED_DIV - 1));
        end else begin : g_nofixed
            assign pre_wrap = 1'b1;
        end
    endgenerate

    assign main_wrap = (main_cnt == presc);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= ST_RELOAD;
        else if (restart) state <= ST_RELOAD;
        else              state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RELOAD:    state_nxt = sel_ext ? ST_EXT_PASS : ST_INT_COUNT;
            ST_EXT_PASS:  state_nxt = ST_EXT_PASS;
            ST_INT_COUNT: state_nxt = ST_INT_COUNT;
            default:      state_nxt = ST_RELOAD;
        endcase
    end

    // Two-stage counter of the internal path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            main_cnt <= '0;
        end else if (restart || (state != ST_INT_COUNT)) begin
            pre_cnt  <= '0;
            main_cnt <= '0;
        end else if (int_tick) begin
            if (pre_wrap) begin
                pre_cnt  <= '0;
                main_cnt <= main_wrap ? '0 : main_cnt + 1'b1;
            end else begin
                pre_cnt  <= pre_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        slow_tick = 1'b0;
        unique case (state)
            ST_RELOAD:    slow_tick = 1'b0;
            ST_EXT_PASS:  slow_tick = ext_tick;
            ST_INT_COUNT: slow_tick = int_tick && pre_wrap && main_wrap;
            default:      slow_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/slowclk_sel.sv
`timescale 1ns/1ps
module slowclk_sel
    import clksel_pkg::*;
#(
    parameter int PRESC_W   = 5,
    parameter int FIXED_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              int_tick,
    input  logic              ext_tick,
    output logic              slow_tick,
    output logic              pin_en,
    output logic              sel_ext
);
    logic [PRESC_W-1:0] presc;
    logic               gate_en;
    logic               cfg_restart;

    clksel_regs #(.PRESC_W(PRESC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sel_ext     (sel_ext),
        .presc       (presc),
        .gate_en     (gate_en),
        .cfg_restart (cfg_restart)
    );

    clksel_divider #(.PRESC_W(PRESC_W), .FIXED_DIV(FIXED_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cfg_restart),
        .sel_ext   (sel_ext),
        .presc     (presc),
        .int_tick  (int_tick),
        .ext_tick  (ext_tick),
        .slow_tick (slow_tick)
    );

    assign pin_en = slow_tick && gate_en;
endmodule

// File: rtl/slowclk_sel_chk.sv
`timescale 1ns/1ps
module slowclk_sel_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              int_tick,
    input logic              ext_tick,
    input logic              slow_tick,
    input logic              pin_en,
    input logic              sel_ext,
    input logic              gate_en
);
    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_CTRL && wr_data[DATA_W-1:DATA_W-KEY_W] != CTRL_KEY)
        |=> $stable(sel_ext)); // R2

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_addr == OFF_CTRL && wr_data[DATA_W-1:DATA_W-KEY_W] == CTRL_KEY)
                   || wr_addr == OFF_PRESC))
        |=> !slow_tick); // R9

    AST_INT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ext && !int_tick) |-> !slow_tick); // R6

    AST_EXT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && !ext_tick) |-> !slow_tick); // R7

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> !pin_en); // R8
endmodule

bind slowclk_sel slowclk_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .int_tick  (int_tick),
    .ext_tick  (ext_tick),
    .slow_tick (slow_tick),
    .pin_en    (pin_en),
    .sel_ext   (sel_ext),
    .gate_en   (gate_en)
);

// File: tb/slowclk_sel_test.sv
`timescale 1ns/1ps
module slowclk_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        int_tick = 1'b1;
    logic        ext_tick = 1'b0;
    logic        slow_tick, pin_en, sel_ext;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    slowclk_sel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_tick(int_tick), .ext_tick(ext_tick), .slow_tick(slow_tick),
        .pin_en(pin_en), .sel_ext(sel_ext)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // write, then read the same offset back
    localparam vec_t VEC [8] = '{
        '{8'h00, 32'h16AA0001, 32'h1},   // R2 good key selects external
        '{8'h00, 32'h00000000, 32'h1},   // R2 missing key ignored
        '{8'h00, 32'h16AB0000, 32'h1},   // R2 near-miss key ignored, R3 key reads 0
        '{8'h08, 32'hFFFFFFFF, 32'h1F},  // R4 only five bits kept
        '{8'h60, 32'h00000003, 32'h1},   // R5 gate bit
        '{8'h00, 32'h16AA0000, 32'h0},   // R2 back to internal
        '{8'h08, 32'h00000025, 32'h5},   // R4
        '{8'h60, 32'h00000000, 32'h0}    // R5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic measure(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (slow_tick || n > 5000) break;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 tick after reset", 32'(slow_tick), 0);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h08, d); chk("R1 presc", d, 0);
        rd(8'h60, d); chk("R1 gate", d, 0);
        measure(n); chk("R6 default period", n, 32);
        measure(n); chk("R6 default period repeat", n, 32);

        foreach (VEC[i]) begin
            wr(VEC[i].addr, VEC[i].data);
            rd(VEC[i].addr, d);
            chk($sformatf("R2/R3/R4/R5 vector %0d", i), d, VEC[i].exp);
        end

        // prescaler 5 set by the table; rewrite to restart
        wr(8'h08, 32'd5);
        measure(n); chk("R6 period N=5", n, 192);
        measure(n); chk("R6 period N=5 repeat", n, 192);
        wr(8'h08, 32'd2);
        measure(n); chk("R6 period N=2", n, 96);

        // rejected key mid-count: no restart, no source change
        wr(8'h00, 32'h00000001);
        measure(n); chk("R9 rejected write keeps phase", n, 95);
        rd(8'h00, d); chk("R2 select unchanged", d, 0);

        // accepted write mid-count restarts
        repeat (10) @(negedge clk);
        wr(8'h08, 32'd2);
        measure(n); chk("R9 restart full period", n, 96);

        // unmapped offset
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h00, d); chk("R10 ctrl", d, 0);
        rd(8'h08, d); chk("R10 presc", d, 2);
        rd(8'h60, d); chk("R10 gate", d, 0);
        rd(8'h04, d); chk("R10 read unmapped", d, 0);

        // pin gating, internal mode
        wr(8'h60, 32'h1);
        measure(n); chk("R8 pin follows tick", 32'(pin_en), 1);

        // external mode
        wr(8'h00, 32'h16AA0001);
        @(negedge clk);
        ext_tick = 1'b0; int_tick = 1'b1; #1;
        chk("R7 internal ignored", 32'(slow_tick), 0);
        ext_tick = 1'b1; #1;
        chk("R7 passthrough", 32'(slow_tick), 1);
        chk("R8 pin gated on", 32'(pin_en), 1);
        ext_tick = 1'b0;
        wr(8'h60, 32'h0);
        ext_tick = 1'b1; #1;
        chk("R8 pin gated off", 32'(pin_en), 0);
        wr(8'h00, 32'h16AA0001); #1;
        chk("R9 quiet cycle after write", 32'(slow_tick), 0);
        @(negedge clk); #1;
        chk("R7 resumes after reload", 32'(slow_tick), 1);
        ext_tick = 1'b0;

        // back to internal, prescaler 0
        wr(8'h00, 32'h16AA0000);
        wr(8'h08, 32'h0);
        measure(n); chk("R6 period after source switch", n, 32);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule